// File: doc/BRIEF.md
# IR Carrier-Modulated Burst Transmitter

This block drives an infrared emitter line with a burst of alternating lit and dark intervals. A write port fills a circular queue with 16-bit interval durations, given as raw timer counts. A start strobe launches the burst. An interval timer then walks through the queue. Each stored value sets how long the current level is held, and the level flips every time an interval ends. The first interval is always lit.

The lit level is gated by a free-running square-wave carrier. The carrier's half period is set through a small register port, and the current setting can be read back. The emitter pin is the AND of the envelope level and the carrier. When the queue runs dry at the end of an interval, the transmitter stops its timer, forces the line low, clears its busy flag and pulses done for one cycle.

Entries may be appended while a burst is running, and they join that same burst. The write port uses a valid/ready handshake. A writer facing a full queue is held off and never overwrites stored data.

Top module: `irtx_burst_top`

## Requirements
- R1: After a synchronous reset, busy, done, env_o and ir_out are 0, wr_ready is 1, car_rdata is 0, and the carrier is disabled.
- R2: The queue holds at most 2**ADDR_W - 1 entries. wr_ready is 0 exactly when it is full. An offered word is taken only while wr_ready is 1, and accepted entries are transmitted in write order, unchanged.
- R3: A start strobe while the transmitter is idle and the queue is empty has no effect, and busy stays 0.
- R4: A start strobe while idle with a non-empty queue sets busy and env_o to 1 from the next cycle. The first entry N holds env_o high for (N+1)*PRESCALE clock cycles.
- R5: Each following entry N flips env_o and holds the new level for (N+1)*PRESCALE cycles, so levels alternate high, low, high, and so on.
- R6: When an interval ends with the queue empty, busy and env_o drop to 0 in the same cycle that done is 1. done is high for exactly one cycle per burst.
- R7: A start strobe while busy is ignored and does not alter the interval timing.
- R8: After the carrier is written with a non-zero value D, the carrier starts low and toggles every D+1 clock cycles. ir_out equals env_o AND the carrier.
- R9: A carrier value of 0 disables the carrier, so ir_out stays 0 even while env_o is 1.
- R10: car_rdata returns the last value written to the carrier register.
- R11: Entries written while a burst is running join the same burst without a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Interval word offered |
| wr_data | input | DUR_W | Interval duration in ticks minus one |
| wr_ready | output | 1 | Queue can accept a word |
| start | input | 1 | Start strobe for a burst |
| car_wr | input | 1 | Carrier register write strobe |
| car_wdata | input | CAR_W | Carrier half period minus one, 0 turns it off |
| car_rdata | output | CAR_W | Current carrier register value |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when a burst ends |
| env_o | output | 1 | Envelope level |
| ir_out | output | 1 | Modulated emitter drive |

## Verification
The bench builds the block with ADDR_W=3 and PRESCALE=4, keeping DUR_W=16 and CAR_W=8. The small queue lets the full condition and write stalls be reached with a handful of words. The short prescaler keeps every interval a few dozen cycles long, so each lit and dark run can be measured exactly. With a carrier half period of three cycles, the bench can compare ir_out against the predicted square wave cycle by cycle during a mark.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

endpackage

// File: rtl/irtx_ring.sv
module irtx_ring #(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic [AW-1:0] level
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q;
   logic [AW-1:0] rp_q;

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp_q] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_comb begin
      head  = mem[rp_q];
      empty = (wp_q == rp_q);
      full  = (AW'(wp_q + 1'b1) == rp_q);
      level = wp_q - rp_q;
   end

endmodule

// File: rtl/irtx_prescale.sv
module irtx_prescale #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick = run & ~clr;
      end else begin : g_count
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pc_q;

         always_ff @(posedge clk) begin
            if (rst || clr || !run) begin
               pc_q <= '0;
            end else if (pc_q == PW'(DIV - 1)) begin
               pc_q <= '0;
            end else begin
               pc_q <= pc_q + 1'b1;
            end
         end

         assign tick = run & ~clr & (pc_q == PW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/irtx_envelope.sv
module irtx_envelope
   import irtx_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          q_empty,
   input  logic [DW-1:0] q_head,
   input  logic          tick,
   output logic          pop,
   output logic          launch,
   output logic          busy,
   output logic          env,
   output logic          done
);
   tx_state_e     st_q;
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] cmp_q;
   logic          env_q;
   logic          done_q;
   logic          match;

   always_comb begin
      launch = (st_q == TX_IDLE) && start && !q_empty;
      match  = (st_q == TX_SEND) && tick && (cnt_q == cmp_q);
      pop    = launch || (match && !q_empty);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= TX_IDLE;
         cnt_q  <= '0;
         cmp_q  <= '0;
         env_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            TX_IDLE: begin
               if (launch) begin
                  st_q  <= TX_SEND;
                  env_q <= 1'b1;
                  cnt_q <= '0;
                  cmp_q <= q_head;
               end
            end
            TX_SEND: begin
               if (tick) begin
                  if (cnt_q == cmp_q) begin
                     cnt_q <= '0;
                     if (!q_empty) begin
                        env_q <= ~env_q;
                        cmp_q <= q_head;
                     end else begin
                        st_q   <= TX_IDLE;
                        env_q  <= 1'b0;
                        done_q <= 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign busy = (st_q == TX_SEND);
   assign env  = env_q;
   assign done = done_q;

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] div,
   output logic          sq
);
   logic [CW-1:0] div_q;
   logic [CW-1:0] cc_q;
   logic          sq_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         cc_q  <= '0;
         sq_q  <= 1'b0;
      end else if (wr) begin
         div_q <= wdata;
         cc_q  <= '0;
         sq_q  <= 1'b0;
      end else if (div_q == '0) begin
         cc_q  <= '0;
         sq_q  <= 1'b0;
      end else if (cc_q == div_q) begin
         cc_q  <= '0;
         sq_q  <= ~sq_q;
      end else begin
         cc_q  <= cc_q + 1'b1;
      end
   end

   assign div = div_q;
   assign sq  = sq_q;

endmodule

// File: rtl/irtx_burst_top.sv
module irtx_burst_top #(
   parameter int DUR_W    = 16,
   parameter int ADDR_W   = 8,
   parameter int PRESCALE = 8,
   parameter int CAR_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_valid,
   input  logic [DUR_W-1:0] wr_data,
   output logic             wr_ready,
   input  logic             start,
   input  logic             car_wr,
   input  logic [CAR_W-1:0] car_wdata,
   output logic [CAR_W-1:0] car_rdata,
   output logic             busy,
   output logic             done,
   output logic             env_o,
   output logic             ir_out
);
   generate
      if (DUR_W < 2) begin : g_bad_dur
         $error("DUR_W must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
         $error("ADDR_W must lie in 2..10");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (CAR_W < 1) begin : g_bad_car
         $error("CAR_W must be at least 1");
      end
   endgenerate

   logic              q_push;
   logic              q_pop;
   logic [DUR_W-1:0]  q_head;
   logic              q_empty;
   logic              q_full;
   logic [ADDR_W-1:0] q_level;
   logic              tick;
   logic              launch;
   logic              car_sq;

   assign wr_ready = ~q_full;
   assign q_push   = wr_valid & ~q_full;

   irtx_ring #(.DW(DUR_W), .AW(ADDR_W)) u_ring (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push),
      .push_data (wr_data),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full),
      .level     (q_level)
   );

   irtx_prescale #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .run  (busy),
      .clr  (launch),
      .tick (tick)
   );

   irtx_envelope #(.DW(DUR_W)) u_env (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .q_empty (q_empty),
      .q_head  (q_head),
      .tick    (tick),
      .pop     (q_pop),
      .launch  (launch),
      .busy    (busy),
      .env     (env_o),
      .done    (done)
   );

   irtx_carrier #(.CW(CAR_W)) u_car (
      .clk   (clk),
      .rst   (rst),
      .wr    (car_wr),
      .wdata (car_wdata),
      .div   (car_rdata),
      .sq    (car_sq)
   );

   assign ir_out = env_o & car_sq;

endmodule

// File: rtl/irtx_burst_chk.sv
module irtx_burst_chk #(
   parameter int AW = 8,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          wr_ready,
   input logic          busy,
   input logic          done,
   input logic          env_o,
   input logic          ir_out,
   input logic [CW-1:0] car_rdata,
   input logic [AW-1:0] q_level
);
   localparam int DEPTH = 1 << AW;

   a_r1_idle_dark: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!ir_out && !env_o));

   a_r2_ready_full: assert property (@(posedge clk) disable iff (rst)
      !wr_ready |-> (q_level == AW'(DEPTH - 1)));

   a_r3_empty_start: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && q_level == '0) |=> !busy);

   a_r6_done_ends: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (!busy && $past(busy)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r8_gated: assert property (@(posedge clk) disable iff (rst)
      ir_out |-> env_o);

   a_r9_car_off: assert property (@(posedge clk) disable iff (rst)
      (car_rdata == '0) |-> !ir_out);

endmodule

bind irtx_burst_top irtx_burst_chk #(.AW(ADDR_W), .CW(CAR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .wr_ready  (wr_ready),
   .busy      (busy),
   .done      (done),
   .env_o     (env_o),
   .ir_out    (ir_out),
   .car_rdata (car_rdata),
   .q_level   (q_level)
);

// File: tb/sim_irtx_burst_top.sv
`timescale 1ns/1ps
module sim_irtx_burst_top;
   localparam int DW  = 16;
   localparam int AW  = 3;
   localparam int PS  = 4;
   localparam int CW  = 8;
   localparam int CAP = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          start = 1'b0;
   logic          car_wr = 1'b0;
   logic [CW-1:0] car_wdata = '0;
   logic [CW-1:0] car_rdata;
   logic          busy, done, env_o, ir_out;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int w0 = 0;
   int car_d = 0;

   int runs [32];
   int lvls [32];
   int nruns;
   int ndone;
   int ir_err;
   int done_ok;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   irtx_burst_top #(.DUR_W(DW), .ADDR_W(AW), .PRESCALE(PS), .CAR_W(CW)) u0 (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .start(start), .car_wr(car_wr),
      .car_wdata(car_wdata), .car_rdata(car_rdata), .busy(busy),
      .done(done), .env_o(env_o), .ir_out(ir_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   task automatic push(input int d);
      int waitc;
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = DW'(d);
      waitc = 0;
      while (!wr_ready && waitc < 2000) begin
         @(negedge clk);
         waitc++;
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic set_carrier(input int d);
      @(negedge clk);
      car_wr    = 1'b1;
      car_wdata = CW'(d);
      @(negedge clk);
      car_wr = 1'b0;
      w0     = cyc;
      car_d  = d;
   endtask

   // Records level runs from the current negedge until busy falls.
   task automatic capture();
      int prev, len, guard, expsq;
      nruns = 0; ndone = 0; ir_err = 0; done_ok = 0;
      prev = env_o; len = 0; guard = 0;
      while (guard < 5000) begin
         guard++;
         if (done) ndone++;
         if (!busy) begin
            if (done && !env_o) done_ok = 1;
            break;
         end
         if (int'(env_o) != prev) begin
            runs[nruns] = len; lvls[nruns] = prev; nruns++;
            prev = env_o; len = 0;
         end
         expsq = (car_d != 0 && env_o) ? (((cyc - w0) / (car_d + 1)) % 2) : 0;
         if (int'(ir_out) != expsq) ir_err++;
         len++;
         @(negedge clk);
      end
      runs[nruns] = len; lvls[nruns] = prev; nruns++;
      @(negedge clk);
      if (done) ndone++;
   endtask

   task automatic check_runs(input string req, input int vals [], input int n);
      chk(nruns == n, req, nruns, n);
      for (int i = 0; i < n && i < nruns; i++) begin
         chk(runs[i] == (vals[i] + 1) * PS, req, runs[i], (vals[i] + 1) * PS);
         chk(lvls[i] == ((i % 2) == 0 ? 1 : 0), req, lvls[i], (i % 2) == 0 ? 1 : 0);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(busy == 0,     "R1 busy",     busy, 0);
      chk(done == 0,     "R1 done",     done, 0);
      chk(env_o == 0,    "R1 env",      env_o, 0);
      chk(ir_out == 0,   "R1 ir_out",   ir_out, 0);
      chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
      chk(car_rdata == 0, "R1 car_rdata", car_rdata, 0);
   endtask

   task automatic t_empty_start();
      int seen;
      seen = 0;
      pulse_start();
      for (int i = 0; i < 10; i++) begin
         if (busy || env_o) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R3 start on empty queue", seen, 0);
   endtask

   task automatic t_single();
      int v [] = '{3};
      set_carrier(1);
      push(3);
      pulse_start();
      chk(busy == 1, "R4 busy after start", busy, 1);
      capture();
      check_runs("R4 single mark", v, 1);
      chk(ndone == 1, "R6 done count", ndone, 1);
      chk(done_ok == 1, "R6 done with busy low", done_ok, 1);
      chk(env_o == 0, "R6 env low after drain", env_o, 0);
   endtask

   task automatic t_multi();
      int v [] = '{2, 0, 4, 1};
      foreach (v[i]) push(v[i]);
      pulse_start();
      capture();
      check_runs("R5 alternating intervals", v, 4);
      chk(ndone == 1, "R6 done once per burst", ndone, 1);
   endtask

   task automatic t_full();
      int acc, ok;
      int v [] = '{0, 1, 2, 3, 4, 5, 6};
      acc = 0;
      for (int i = 0; i < CAP + 1; i++) begin
         @(negedge clk);
         wr_valid = 1'b1;
         wr_data  = DW'(i);
         ok = wr_ready;
         if (ok) acc++;
      end
      @(negedge clk);
      chk(wr_ready == 0, "R2 ready low when full", wr_ready, 0);
      wr_valid = 1'b1;
      wr_data  = DW'(99);
      repeat (3) @(negedge clk);
      wr_valid = 1'b0;
      chk(acc == CAP, "R2 capacity", acc, CAP);
      pulse_start();
      capture();
      check_runs("R2 order kept, no overwrite", v, CAP);
   endtask

   task automatic t_stream();
      int v [] = '{5, 5, 2, 3};
      push(5);
      push(5);
      pulse_start();
      fork
         capture();
         begin
            push(2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            push(3);
         end
      join
      check_runs("R11 appended entries, R7 start while busy", v, 4);
      chk(ndone == 1, "R7 single done", ndone, 1);
   endtask

   task automatic t_carrier();
      int v [] = '{9};
      set_carrier(2);
      chk(car_rdata == 2, "R10 readback", car_rdata, 2);
      push(9);
      pulse_start();
      capture();
      check_runs("R8 mark length", v, 1);
      chk(ir_err == 0, "R8 carrier gating", ir_err, 0);
   endtask

   task automatic t_carrier_off();
      int v [] = '{5};
      set_carrier(0);
      chk(car_rdata == 0, "R10 readback zero", car_rdata, 0);
      push(5);
      pulse_start();
      capture();
      check_runs("R9 envelope unaffected", v, 1);
      chk(ir_err == 0, "R9 output low with carrier off", ir_err, 0);
   endtask

   initial begin
      t_reset();
      t_empty_start();
      t_single();
      t_multi();
      t_full();
      t_stream();
      t_carrier();
      t_carrier_off();
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule